// File: doc/BRIEF.md
# USB Endpoint Handshake Status Controller

This block keeps the software-visible status and configuration of a single USB device endpoint and chooses the handshake answer for every token the serial engine decodes for that endpoint. Software configures a transmit status, a receive status, a control-endpoint flag and an isochronous flag through a write port. The serial engine presents each decoded token as a strobe with the two upper PID bits. One clock later the block returns a registered decision: no answer, STALL, NAK, or accept (send data / ACK).

When the engine reports that an accepted transaction finished correctly, the block raises the correct-transfer flag (CTR). After an IN or control SETUP transfer on a non-isochronous endpoint, it also moves the transmit status to NAK, so the host is held off until software has prepared the next data. The PID of the last answered token is kept readable. That field freezes while CTR is set, so software can still see which token caused the interrupt. Packet serialisation, CRC, the bit layer and buffer memory sit outside this block.

Top module: `usb_ep_hs_ctrl`

## Requirements
- R1: After reset, tx_stat and rx_stat are 00, ctl_ep, iso_ep and ctr_flag are 0, pid_rcv is 00 and resp_vld is 0.
- R2: Status and response codes are 00 disabled/none, 01 STALL, 10 NAK, 11 valid/accept. The token PID codes are 00 OUT, 10 IN, 11 SETUP. For an IN token, resp equals tx_stat. For an OUT token, resp equals rx_stat. resp_vld is 1 and resp carries the decision in the cycle after the token strobe. Otherwise resp_vld is 0 and resp is 00.
- R3: A SETUP token on a non-control endpoint gets response 00. On a control endpoint, it gets 00 when rx_stat is 00 or 10, and 11 when rx_stat is 01 or 11.
- R4: A xfer_ok pulse that follows a response of 11 to an IN or SETUP token, on a non-isochronous endpoint, sets tx_stat to 10 in the next cycle. This takes priority over a software write in the same cycle. A transfer completed for an OUT token leaves tx_stat unchanged.
- R5: pid_rcv takes the PID of every token answered with a non-zero response, one cycle after the token, unless ctr_flag is 1, in which case pid_rcv holds its value.
- R6: ctr_flag becomes 1 in the cycle after a xfer_ok pulse that follows a response of 11, with no newer token in between. A xfer_ok pulse with no such pending transaction has no effect.
- R7: ctr_flag is cleared only by a software write with bit 6 = 0. A write with bit 6 = 1 leaves it unchanged. Setting CTR takes priority over a clear in the same cycle.
- R8: While iso_ep is 1, a completed transfer changes neither tx_stat nor rx_stat.
- R9: A token answered with 00 (disabled status, PID code 01, or a refused SETUP) changes neither ctr_flag nor pid_rcv, and it cancels any pending transaction.
- R10: A software write sets tx_stat from bits 5:4, rx_stat from bits 3:2, ctl_ep from bit 1 and iso_ep from bit 0, all visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_vld | input | 1 | Token addressed to this endpoint, one-cycle strobe |
| tok_pid | input | 2 | Upper two PID bits of the token |
| xfer_ok | input | 1 | Last accepted transaction completed correctly |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 7 | Write word: [6] CTR keep, [5:4] tx, [3:2] rx, [1] control, [0] isochronous |
| resp_vld | output | 1 | Registered decision valid |
| resp | output | 2 | Handshake decision |
| ctr_flag | output | 1 | Correct-transfer flag |
| pid_rcv | output | 2 | PID of last answered token |
| tx_stat | output | 2 | Transmit status |
| rx_stat | output | 2 | Receive status |
| ctl_ep | output | 1 | Control-endpoint flag |
| iso_ep | output | 1 | Isochronous flag |

## Verification
The bench looks at the SETUP paths around the receive status. A design that answers a SETUP under receive NAK would wrongly accept it, and one that applies the receive STALL literally would stall a SETUP it must accept. It checks that pid_rcv stays frozen while CTR is set: a design that keeps updating the field would report the wrong token to the interrupt handler. It also checks that an isochronous endpoint keeps its status after a transfer, that a stray xfer_ok or a refused token leaves CTR alone, and that the hardware NAK wins over a software write in the same cycle. Each of those mistakes shows up as a status or flag differing from the cycle-accurate reference.

// File: rtl/usb_ephs_pkg.sv
package usb_ephs_pkg;
   // status codes, also reused as response codes
   localparam logic [1:0] ST_OFF   = 2'b00;
   localparam logic [1:0] ST_STALL = 2'b01;
   localparam logic [1:0] ST_NAK   = 2'b10;
   localparam logic [1:0] ST_VALID = 2'b11;
   // upper PID bits
   localparam logic [1:0] PID_OUT   = 2'b00;
   localparam logic [1:0] PID_IN    = 2'b10;
   localparam logic [1:0] PID_SETUP = 2'b11;
   // software write word layout
   localparam int WORD_W = 7;
   localparam int W_CTR  = 6;
   localparam int W_TX   = 4;
   localparam int W_RX   = 2;
   localparam int W_CTL  = 1;
   localparam int W_ISO  = 0;
endpackage

// File: rtl/ep_resp_decide.sv
module ep_resp_decide
   import usb_ephs_pkg::*;
#(
   parameter int STAT_W = 2,
   parameter int PID_W  = 2
) (
   input  logic [PID_W-1:0]  pid,
   input  logic [STAT_W-1:0] tx,
   input  logic [STAT_W-1:0] rx,
   input  logic              ctl,
   output logic [STAT_W-1:0] resp
);
   if (STAT_W != 2) begin : g_bad_stat
      initial $error("ep_resp_decide: STAT_W must be 2");
   end
   if (PID_W != 2) begin : g_bad_pid
      initial $error("ep_resp_decide: PID_W must be 2");
   end

   always_comb begin
      resp = ST_OFF;
      case (pid)
         PID_IN:    resp = tx;
         PID_OUT:   resp = rx;
         PID_SETUP: if (ctl && (rx == ST_STALL || rx == ST_VALID)) resp = ST_VALID;
         default:   resp = ST_OFF;
      endcase
   end
endmodule

// File: rtl/ep_stat_regs.sv
module ep_stat_regs
   import usb_ephs_pkg::*;
#(
   parameter int              STAT_W = 2,
   parameter logic [STAT_W-1:0] RST_TX = '0,
   parameter logic [STAT_W-1:0] RST_RX = '0,
   parameter bit              ISO_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [STAT_W-1:0] sw_tx,
   input  logic [STAT_W-1:0] sw_rx,
   input  logic              sw_ctl,
   input  logic              sw_iso,
   input  logic              hw_nak,
   output logic [STAT_W-1:0] tx_q,
   output logic [STAT_W-1:0] rx_q,
   output logic              ctl_q,
   output logic              iso_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q  <= RST_TX;
         rx_q  <= RST_RX;
         ctl_q <= 1'b0;
      end else begin
         if (hw_nak && !iso_q) tx_q <= ST_NAK;
         else if (sw_we)       tx_q <= sw_tx;
         if (sw_we) begin
            rx_q  <= sw_rx;
            ctl_q <= sw_ctl;
         end
      end
   end

   if (ISO_EN) begin : g_iso
      always_ff @(posedge clk) begin
         if (!rst_n)     iso_q <= 1'b0;
         else if (sw_we) iso_q <= sw_iso;
      end
   end else begin : g_no_iso
      assign iso_q = 1'b0;
   end

   // R8
   iso_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iso_q && !sw_we) |=> ($stable(tx_q) && $stable(rx_q)));
   // R4
   hw_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_nak && !iso_q) |=> (tx_q == ST_NAK));
endmodule

// File: rtl/ep_xfer_track.sv
module ep_xfer_track
   import usb_ephs_pkg::*;
#(
   parameter int STAT_W = 2,
   parameter int PID_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_vld,
   input  logic [PID_W-1:0]  tok_pid,
   input  logic [STAT_W-1:0] resp_d,
   input  logic              xfer_ok,
   input  logic              ctr_clr,
   output logic              resp_vld_q,
   output logic [STAT_W-1:0] resp_q,
   output logic              ctr_q,
   output logic [PID_W-1:0]  pid_q,
   output logic              nak_req
);
   logic             pend_q;
   logic [PID_W-1:0] kind_q;
   logic             accepted;
   logic             done;

   assign accepted = tok_vld && (resp_d != ST_OFF);
   assign done     = xfer_ok && pend_q;
   assign nak_req  = done && (kind_q == PID_IN || kind_q == PID_SETUP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_vld_q <= 1'b0;
         resp_q     <= ST_OFF;
         ctr_q      <= 1'b0;
         pid_q      <= '0;
         pend_q     <= 1'b0;
         kind_q     <= '0;
      end else begin
         resp_vld_q <= tok_vld;
         resp_q     <= tok_vld ? resp_d : ST_OFF;
         if (accepted && !ctr_q) pid_q <= tok_pid;
         if (tok_vld) begin
            pend_q <= (resp_d == ST_VALID);
            kind_q <= tok_pid;
         end else if (xfer_ok) begin
            pend_q <= 1'b0;
         end
         if (done)         ctr_q <= 1'b1;
         else if (ctr_clr) ctr_q <= 1'b0;
      end
   end

   // R5
   pid_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_q |=> $stable(pid_q));
   // R7
   ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_q && !ctr_clr) |=> ctr_q);
   // R6
   stray_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ok && !pend_q && !ctr_q) |=> !ctr_q);
   // R9
   ign_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_vld && resp_d == ST_OFF && !done && !ctr_clr)
         |=> ($stable(pid_q) && $stable(ctr_q) && !pend_q));
endmodule

// File: rtl/usb_ep_hs_ctrl.sv
module usb_ep_hs_ctrl
   import usb_ephs_pkg::*;
#(
   parameter int STAT_W = 2,
   parameter int PID_W  = 2,
   parameter bit ISO_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_vld,
   input  logic [PID_W-1:0]  tok_pid,
   input  logic              xfer_ok,
   input  logic              sw_we,
   input  logic [6:0]        sw_wdata,
   output logic              resp_vld,
   output logic [STAT_W-1:0] resp,
   output logic              ctr_flag,
   output logic [PID_W-1:0]  pid_rcv,
   output logic [STAT_W-1:0] tx_stat,
   output logic [STAT_W-1:0] rx_stat,
   output logic              ctl_ep,
   output logic              iso_ep
);
   logic [STAT_W-1:0] resp_d;
   logic              nak_req;
   logic              ctr_clr;

   assign ctr_clr = sw_we && !sw_wdata[W_CTR];

   ep_resp_decide #(.STAT_W(STAT_W), .PID_W(PID_W)) i_decide (
      .pid(tok_pid), .tx(tx_stat), .rx(rx_stat), .ctl(ctl_ep), .resp(resp_d));

   ep_stat_regs #(.STAT_W(STAT_W), .ISO_EN(ISO_EN)) i_stat (
      .clk(clk), .rst_n(rst_n), .sw_we(sw_we),
      .sw_tx(sw_wdata[W_TX +: 2]), .sw_rx(sw_wdata[W_RX +: 2]),
      .sw_ctl(sw_wdata[W_CTL]), .sw_iso(sw_wdata[W_ISO]),
      .hw_nak(nak_req),
      .tx_q(tx_stat), .rx_q(rx_stat), .ctl_q(ctl_ep), .iso_q(iso_ep));

   ep_xfer_track #(.STAT_W(STAT_W), .PID_W(PID_W)) i_track (
      .clk(clk), .rst_n(rst_n), .tok_vld(tok_vld), .tok_pid(tok_pid),
      .resp_d(resp_d), .xfer_ok(xfer_ok), .ctr_clr(ctr_clr),
      .resp_vld_q(resp_vld), .resp_q(resp), .ctr_q(ctr_flag),
      .pid_q(pid_rcv), .nak_req(nak_req));

   // R3
   setup_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_vld && tok_pid == PID_SETUP && ctl_ep && rx_stat == ST_NAK)
         |=> (resp_vld && resp == ST_OFF));
   // R2
   resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tok_vld |=> (!resp_vld && resp == ST_OFF));
endmodule

// File: tb/test_usb_ep_hs_ctrl.sv
`timescale 1ns/1ps
module test_usb_ep_hs_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tok_vld = 1'b0;
   logic [1:0] tok_pid = 2'b00;
   logic       xfer_ok = 1'b0;
   logic       sw_we = 1'b0;
   logic [6:0] sw_wdata = '0;
   logic       resp_vld, ctr_flag, ctl_ep, iso_ep;
   logic [1:0] resp, pid_rcv, tx_stat, rx_stat;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   usb_ep_hs_ctrl i_usb_ep_hs_ctrl (
      .clk(clk), .rst_n(rst_n), .tok_vld(tok_vld), .tok_pid(tok_pid),
      .xfer_ok(xfer_ok), .sw_we(sw_we), .sw_wdata(sw_wdata),
      .resp_vld(resp_vld), .resp(resp), .ctr_flag(ctr_flag), .pid_rcv(pid_rcv),
      .tx_stat(tx_stat), .rx_stat(rx_stat), .ctl_ep(ctl_ep), .iso_ep(iso_ep));

   // behavioural reference
   int m_tx, m_rx, m_ctl, m_iso, m_ctr, m_pid, m_resp, m_rv, m_pend, m_kind;

   function automatic int answer(int pid, int tx, int rx, int ctl);
      if (pid == 2) return tx;
      if (pid == 0) return rx;
      if (pid == 3) begin
         if (ctl == 0) return 0;
         if (rx == 1 || rx == 3) return 3;
         return 0;
      end
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tx = 0; m_rx = 0; m_ctl = 0; m_iso = 0; m_ctr = 0;
         m_pid = 0; m_resp = 0; m_rv = 0; m_pend = 0; m_kind = 0;
      end else begin
         int a, o_ctr, o_pend, o_kind, o_iso;
         o_ctr = m_ctr; o_pend = m_pend; o_kind = m_kind; o_iso = m_iso;
         a = tok_vld ? answer(tok_pid, m_tx, m_rx, m_ctl) : 0;
         m_rv = tok_vld; m_resp = a;
         if (tok_vld && a != 0 && o_ctr == 0) m_pid = tok_pid;
         if (tok_vld) begin m_pend = (a == 3); m_kind = tok_pid; end
         else if (xfer_ok) m_pend = 0;
         if (xfer_ok && o_pend) m_ctr = 1;
         else if (sw_we && !sw_wdata[6]) m_ctr = 0;
         if (xfer_ok && o_pend && o_iso == 0 && (o_kind == 2 || o_kind == 3)) m_tx = 2;
         else if (sw_we) m_tx = sw_wdata[5:4];
         if (sw_we) begin
            m_rx = sw_wdata[3:2]; m_ctl = sw_wdata[1]; m_iso = sw_wdata[0];
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // cycle compare against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 resp_vld", resp_vld, m_rv);
         chk("R2/R3 resp", resp, m_resp);
         chk("R6/R7 ctr", ctr_flag, m_ctr);
         chk("R5 pid", pid_rcv, m_pid);
         chk("R4/R10 tx", tx_stat, m_tx);
         chk("R10 rx", rx_stat, m_rx);
         chk("R10 flags", {ctl_ep, iso_ep}, {m_ctl[0], m_iso[0]});
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog expired (all requirements) actual=%0d expected=0", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic wr(logic [6:0] w);
      @(negedge clk); sw_we = 1'b1; sw_wdata = w;
      @(negedge clk); sw_we = 1'b0;
   endtask
   task automatic tk(logic [1:0] p);
      @(negedge clk); tok_vld = 1'b1; tok_pid = p;
      @(negedge clk); tok_vld = 1'b0;
   endtask
   task automatic ok();
      @(negedge clk); xfer_ok = 1'b1;
      @(negedge clk); xfer_ok = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 tx", tx_stat, 0); chk("R1 rx", rx_stat, 0);
      chk("R1 ctr", ctr_flag, 0); chk("R1 pid", pid_rcv, 0);
      chk("R1 flags", {ctl_ep, iso_ep}, 0); chk("R1 resp_vld", resp_vld, 0);
      // R10 write tx valid, rx valid
      wr(7'b1_11_11_0_0);
      chk("R10 tx", tx_stat, 3); chk("R10 rx", rx_stat, 3);
      tk(2'b10);
      chk("R2 IN valid", resp, 3); chk("R5 pid IN", pid_rcv, 2);
      ok();
      chk("R6 ctr set", ctr_flag, 1); chk("R4 tx nak", tx_stat, 2);
      tk(2'b10);
      chk("R2 IN nak", resp, 2);
      tk(2'b00);
      chk("R2 OUT valid", resp, 3); chk("R5 pid frozen", pid_rcv, 2);
      ok();
      chk("R4 OUT keeps tx", tx_stat, 2);
      wr(7'b1_01_11_0_0);
      chk("R7 keep ctr", ctr_flag, 1);
      wr(7'b0_01_11_0_0);
      chk("R7 clear ctr", ctr_flag, 0);
      tk(2'b10);
      chk("R2 IN stall", resp, 1);
      ok();
      chk("R6 stray ok", ctr_flag, 0);
      wr(7'b0_00_00_0_0);
      tk(2'b00);
      chk("R9 disabled resp", resp, 0); chk("R9 pid kept", pid_rcv, 2);
      tk(2'b01);
      chk("R9 pid01 resp", resp, 0);
      ok();
      chk("R9 no ctr", ctr_flag, 0);
      wr(7'b0_11_11_0_0);
      tk(2'b11);
      chk("R3 setup non-ctl", resp, 0);
      wr(7'b0_11_10_1_0);
      tk(2'b11);
      chk("R3 setup rx nak", resp, 0); chk("R9 pid after refused", pid_rcv, 2);
      wr(7'b0_11_01_1_0);
      tk(2'b11);
      chk("R3 setup rx stall", resp, 3); chk("R5 pid setup", pid_rcv, 3);
      ok();
      chk("R4 setup nak", tx_stat, 2); chk("R6 ctr setup", ctr_flag, 1);
      wr(7'b0_11_11_0_1);
      tk(2'b10);
      ok();
      chk("R8 iso tx kept", tx_stat, 3); chk("R8 ctr", ctr_flag, 1);
      wr(7'b0_11_11_0_0);
      tk(2'b10);
      @(negedge clk); xfer_ok = 1'b1; sw_we = 1'b1; sw_wdata = 7'b1_01_11_0_0;
      @(negedge clk); xfer_ok = 1'b0; sw_we = 1'b0;
      chk("R4 hw over sw", tx_stat, 2); chk("R6 ctr", ctr_flag, 1);
      // mixed traffic against the reference
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         tok_vld  = ($urandom % 3) == 0;
         tok_pid  = 2'($urandom);
         xfer_ok  = ($urandom % 4) == 0;
         sw_we    = ($urandom % 8) == 0;
         sw_wdata = 7'($urandom);
      end
      @(negedge clk);
      tok_vld = 1'b0; xfer_ok = 1'b0; sw_we = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule